// File: doc/BRIEF.md
# Parallel Bus Output Latch Controller

This block lets a microcontroller drive a bank of output enables over a narrow parallel bus. It uses an active-low select, an active-low write strobe, a data byte and an active-low disable. A write takes place in two steps. While select and write are both low, the data byte is captured into an input stage. The rising write strobe closes that stage. Only when select rises does the captured byte reach the output register that drives the enables. All bus pins are sampled on the system clock through synchronizers.

Two further behaviours sit beside the normal write. If select and write stay low together for a programmable number of clocks, the block enters a direct mode in which every enable follows its data bit. The disable pin turns every enable off at once, without waiting for a clock, and clears both stages. After disable is released, the enables stay off until a new write has been committed. Each commit of the output register is marked by a one-clock pulse.

Top module: `parlat_ctrl`

## Requirements
- R1: While select and write are both low, the data byte is captured into the input stage and the enables keep their previous value.
- R2: Once write has risen, later changes on the data pins do not alter what the next commit delivers.
- R3: A rising select copies the input stage to the enables. The new value appears on the third rising clock edge after the rise is first sampled and is not visible after the second.
- R4: A write strobe given while select is high loads nothing. A later select pulse with no write re-commits the old content.
- R5: `commitPulse` is high for exactly one clock per commit.
- R6: When select and write have both been sampled low for DIRECT_HOLD consecutive clocks, `directMode` is set and each `outEn[i]` follows `dataIn[i]`. `commitPulse` is never high while `directMode` is set.
- R7: Select and write held low together for fewer than DIRECT_HOLD clocks leave `directMode` clear and the enables unchanged.
- R8: Disable low forces every enable to 0 combinationally, with no clock edge needed.
- R9: Disable clears the input stage and the output register. After release, the enables stay 0 until a write and a select rise have occurred.
- R10: During reset, every enable is 0, `commitPulse` is 0 and `directMode` is 0.
- R11: A select rise while disable is low produces no commit pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low select |
| wrN | input | 1 | Active-low write strobe |
| disN | input | 1 | Active-low asynchronous disable |
| dataIn | input | DATA_W | Data byte; bit i controls enable i |
| outEn | output | DATA_W | Output enables |
| commitPulse | output | 1 | One-clock marker of an output register update |
| directMode | output | 1 | High while direct mode is active |

## Verification
The bench builds the block with DIRECT_HOLD set to 8 and keeps the default 8-bit width and two synchronizer stages. The short threshold makes direct mode reachable within about twenty clocks. It also allows an ordinary write with select and write low for only a few clocks to be placed just under the limit, so the boundary between a write cycle and direct mode can be tested both ways. With two synchronizer stages, the commit latency is exactly three edges and can be pinned down cycle by cycle.

// File: rtl/plc_pkg.sv
package plc_pkg;
  // Strobes from control to datapath, valid in the current clock.
  typedef struct packed {
    logic loadIn;    // capture synchronized data into the input stage
    logic commit;    // copy input stage to output register
    logic clearAll;  // disable active: clear both stages
    logic direct;    // direct mode active: enables follow data
  } plc_strobe_t;
endpackage

// File: rtl/plc_sync.sv
module plc_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/plc_ctrl.sv
module plc_ctrl
  import plc_pkg::*;
#(
  parameter int DIRECT_HOLD = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csS,
  input  logic        wrS,
  input  logic        disS,
  output plc_strobe_t strobe
);
  localparam int CNT_W = $clog2(DIRECT_HOLD + 1);
  localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(DIRECT_HOLD);

  logic             csPrev;
  logic [CNT_W-1:0] holdCnt;
  logic             csRise;
  logic             bothLow;

  assign csRise  = csS & ~csPrev;
  assign bothLow = ~csS & ~wrS;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) csPrev <= 1'b1;
    else        csPrev <= csS;

  // Consecutive clocks with select and write low; any select high,
  // write high or disable restarts the qualification.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     holdCnt <= '0;
    else if (!disS || !bothLow)     holdCnt <= '0;
    else if (holdCnt != HOLD_V)     holdCnt <= holdCnt + 1'b1;

  always_comb begin
    strobe.loadIn   = bothLow & disS;
    strobe.commit   = csRise & disS;
    strobe.clearAll = ~disS;
    strobe.direct   = (holdCnt == HOLD_V);
  end
endmodule

// File: rtl/plc_datapath.sv
module plc_datapath
  import plc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disN,
  input  logic [DATA_W-1:0] dataS,
  input  plc_strobe_t       strobe,
  output logic [DATA_W-1:0] outEn,
  output logic              commitPulse
);
  logic [DATA_W-1:0] inStage;
  logic [DATA_W-1:0] outReg;
  logic              pulseQ;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               inStage <= '0;
    else if (strobe.clearAll) inStage <= '0;
    else if (strobe.loadIn)   inStage <= dataS;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               outReg <= '0;
    else if (strobe.clearAll) outReg <= '0;
    else if (strobe.commit)   outReg <= inStage;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pulseQ <= 1'b0;
    else        pulseQ <= strobe.commit;

  // Per-bit output gate: raw disable overrides, then mode select.
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign outEn[i] = disN & (strobe.direct ? dataS[i] : outReg[i]);
  end

  assign commitPulse = pulseQ;
endmodule

// File: rtl/parlat_ctrl.sv
module parlat_ctrl
  import plc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIRECT_HOLD = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csN,
  input  logic              wrN,
  input  logic              disN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] outEn,
  output logic              commitPulse,
  output logic              directMode
);
  logic [2:0]        ctlS;
  logic [DATA_W-1:0] dataS;
  plc_strobe_t       strobe;

  plc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) i_ctlSync (
    .clk(clk), .rst_n(rst_n), .din({csN, wrN, disN}), .dout(ctlS)
  );

  plc_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_dataSync (
    .clk(clk), .rst_n(rst_n), .din(dataIn), .dout(dataS)
  );

  plc_ctrl #(.DIRECT_HOLD(DIRECT_HOLD)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .csS(ctlS[2]), .wrS(ctlS[1]), .disS(ctlS[0]),
    .strobe(strobe)
  );

  plc_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .disN(disN), .dataS(dataS),
    .strobe(strobe), .outEn(outEn), .commitPulse(commitPulse)
  );

  assign directMode = strobe.direct;
endmodule

// File: rtl/plc_checker.sv
module plc_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              disN,
  input logic [DATA_W-1:0] outEn,
  input logic              commitPulse,
  input logic              directMode
);
  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |-> (outEn == '0 && !commitPulse && !directMode));

  p_dis_forces_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !disN |-> (outEn == '0));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commitPulse |=> !commitPulse);

  p_no_commit_in_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commitPulse |-> !directMode);

  p_hold_without_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (disN && $past(disN) && !commitPulse && !directMode && !$past(directMode))
      |-> $stable(outEn));
endmodule

bind parlat_ctrl plc_checker #(.DATA_W(DATA_W)) i_plcChk (
  .clk(clk), .rst_n(rst_n), .disN(disN), .outEn(outEn),
  .commitPulse(commitPulse), .directMode(directMode)
);

// File: tb/test_parlat_ctrl.sv
module test_parlat_ctrl;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         csN = 1'b1;
  logic         wrN = 1'b1;
  logic         disN = 1'b1;
  logic [W-1:0] dataIn = '0;
  logic [W-1:0] outEn;
  logic         commitPulse;
  logic         directMode;

  int checks = 0;
  int errors = 0;
  int pulseCnt = 0;
  bit done = 0;

  // {data written, data driven after write rises}
  localparam logic [15:0] VEC [6] = '{
    16'h01_FE, 16'h02_FF, 16'h80_00, 16'h55_AA, 16'hAA_55, 16'hC3_3C
  };

  always #5 clk = ~clk;

  parlat_ctrl #(.DATA_W(W), .SYNC_STAGES(2), .DIRECT_HOLD(8)) i_parlat_ctrl (
    .clk(clk), .rst_n(rst_n), .csN(csN), .wrN(wrN), .disN(disN),
    .dataIn(dataIn), .outEn(outEn), .commitPulse(commitPulse),
    .directMode(directMode)
  );

  always @(posedge clk) if (rst_n && commitPulse) pulseCnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Full write cycle with exact commit-latency checks.
  task automatic doWrite(input logic [W-1:0] d, input logic [W-1:0] after,
                         input logic [W-1:0] prev);
    int p0;
    csN = 1'b0; cyc(1);
    dataIn = d; wrN = 1'b0; cyc(3);
    chk(outEn == prev, "R1 hold during write", outEn, prev);
    wrN = 1'b1; cyc(1);
    dataIn = after; cyc(2);
    p0 = pulseCnt;
    csN = 1'b1; cyc(2);
    chk(outEn == prev, "R3 not before third edge", outEn, prev);
    cyc(1);
    chk(outEn == d, "R3 R2 committed value", outEn, d);
    cyc(3);
    chk(pulseCnt - p0 == 1, "R5 one pulse per commit", pulseCnt - p0, 1);
  endtask

  initial begin
    logic [W-1:0] last;
    int p0;
    cyc(3);
    chk(outEn == 0 && !commitPulse && !directMode, "R10 reset state",
        {outEn, commitPulse, directMode}, 0);
    rst_n = 1'b1; cyc(2);

    last = '0;
    for (int v = 0; v < 6; v++) begin
      doWrite(VEC[v][15:8], VEC[v][7:0], last);
      last = VEC[v][15:8];
    end

    // R7: both low just under the threshold is an ordinary write
    csN = 1'b0; wrN = 1'b0; dataIn = 8'h0F; cyc(5);
    chk(!directMode, "R7 below threshold", directMode, 0);
    chk(outEn == last, "R7 enables unchanged", outEn, last);
    wrN = 1'b1; cyc(1); csN = 1'b1; cyc(5);
    chk(outEn == 8'h0F, "R7 normal commit", outEn, 8'h0F);

    // R6: direct mode
    csN = 1'b0; wrN = 1'b0; dataIn = 8'hA5; cyc(20);
    chk(directMode, "R6 direct entered", directMode, 1);
    chk(outEn == 8'hA5, "R6 follows data", outEn, 8'hA5);
    dataIn = 8'h3C; cyc(4);
    chk(outEn == 8'h3C, "R6 follows change", outEn, 8'h3C);
    csN = 1'b1; wrN = 1'b1; cyc(6);
    chk(!directMode, "R6 direct left", directMode, 0);
    chk(outEn == 8'h3C, "R6 last value kept", outEn, 8'h3C);

    // R4: write with select high loads nothing
    wrN = 1'b0; dataIn = 8'hFF; cyc(4); wrN = 1'b1; cyc(2);
    csN = 1'b0; cyc(2); csN = 1'b1; cyc(6);
    chk(outEn == 8'h3C, "R4 ignored write", outEn, 8'h3C);

    // R8: disable acts without a clock
    @(negedge clk); disN = 1'b0; #1;
    chk(outEn == 0, "R8 immediate off", outEn, 0);
    cyc(4);
    // R11: select rise during disable gives no pulse
    p0 = pulseCnt;
    csN = 1'b0; cyc(2); csN = 1'b1; cyc(6);
    chk(pulseCnt == p0, "R11 no pulse while disabled", pulseCnt - p0, 0);
    disN = 1'b1; cyc(6);
    chk(outEn == 0, "R9 off after release", outEn, 0);
    csN = 1'b0; cyc(2); csN = 1'b1; cyc(6);
    chk(outEn == 0, "R9 cleared input stage", outEn, 0);
    doWrite(8'h5A, 8'h00, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule